// File: doc/BRIEF.md
# SDRAM Read/Write Data Mask Latency Path

This block sits next to an SDRAM command sequencer and handles the data side of each access. It watches the commands the sequencer issues, tracks whether the open burst is a read or a write, and produces per-beat timing for the data bus. Read beats are delayed by the programmed CAS latency of 2 or 3, so that the capture strobe lines up with the data the memory returns. The byte mask is delayed by two clocks on reads and by zero clocks on writes.

A registered copy of the clock enable gates every pipeline stage. When the clock enable is low, all in-flight read beats and mask stages hold their values. No new beats or commands are accepted in those cycles. Both entry into and exit from this suspend take one clock.

The data path has either one byte lane or two byte lanes. With two lanes there is a separate mask for the lower byte and for the upper byte.

Top module: `sdram_dq_path`

## Requirements
- R1: While reset is asserted, and in the cycles that follow it before any command, rd_valid_o, rd_en_o, wr_strb_o and dq_oe_o are all low.
- R2: cmd_i 2'b01 is a read and 2'b00 is no command. A read beat is issued in the read command cycle. Another read beat is issued in each later cycle with cmd_i 2'b00 and burst_act_i high, while the last command was a read. With cas_lat3_i low, rd_valid_o is high exactly 2 clock-enabled cycles after each read beat.
- R3: With cas_lat3_i high, rd_valid_o is high exactly 3 clock-enabled cycles after each read beat.
- R4: rd_en_o[l] equals rd_valid_o, except that it is low when dqm_i[l] was high 2 clock-enabled cycles earlier.
- R5: cmd_i 2'b10 is a write. Write beats are issued in the same way as read beats in R2. In every write beat dq_oe_o is high. In the same cycle, wr_strb_o[l] is the inverse of dqm_i[l], so the mask has zero latency.
- R6: Lane 0 (bit 0 of dqm_i, rd_en_o and wr_strb_o) is the lower byte and lane 1 is the upper byte. LANES is 1 or 2.
- R7: cmd_i 2'b11 stops the burst. The stop cycle and every later burst_act_i cycle issue no beat until a new read or write command arrives. Write beats issued before the stop still get their strobes.
- R8: When cke_i is low at an edge, the next cycle is suspended. In that cycle no beat is issued, commands are ignored, the read and mask pipelines hold, and rd_valid_o is low. When cke_i returns high, operation resumes one clock later from the held state.
- R9: rd_valid_o and rd_en_o are low in any cycle where dq_oe_o is high. A read beat that meets a write beat is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_i | input | 2 | Issued command: 00 none, 01 read, 10 write, 11 burst stop |
| cas_lat3_i | input | 1 | CAS latency select: 0 gives 2, 1 gives 3 |
| dqm_i | input | LANES | Byte mask, one bit per lane |
| burst_act_i | input | 1 | Burst continues this cycle |
| cke_i | input | 1 | Clock enable as driven to the memory |
| rd_valid_o | output | 1 | Capture read data this cycle |
| rd_en_o | output | LANES | Per-lane read capture enable after the mask |
| wr_strb_o | output | LANES | Per-lane write strobe |
| dq_oe_o | output | 1 | Drive enable for the data bus |

## Verification
The assertions assume that cas_lat3_i changes only while no read beat is in flight. They also assume that the sequencer drives burst_act_i only inside a burst it opened. The bench changes the latency only after the read pipeline has drained, and it keeps burst_act_i low when it wants no beat. The assertions also assume that a read followed by a write is resolved at the data path by dropping the colliding read beat. The bench therefore builds its read/write overlap case so that exactly one read beat meets the write.

// File: rtl/sdram_dq_pkg.sv
package sdram_dq_pkg;
  typedef enum logic [1:0] {
    CMD_NOP  = 2'b00,
    CMD_RD   = 2'b01,
    CMD_WR   = 2'b10,
    CMD_STOP = 2'b11
  } dq_cmd_e;

  typedef enum logic [1:0] {
    DIR_NONE = 2'b00,
    DIR_RD   = 2'b01,
    DIR_WR   = 2'b10
  } dq_dir_e;

  localparam int unsigned CL_MAX  = 3;
  localparam int unsigned DQM_LAT = 2;
endpackage

// File: rtl/sdram_cke_sync.sv
module sdram_cke_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cke_i,
  output logic clk_en_o
);
  logic cke_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cke_q <= 1'b0;
    else         cke_q <= cke_i;
  end

  assign clk_en_o = cke_q;

  AST_CKE_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cke_i) |=> clk_en_o); // R8
  AST_CKE_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cke_i) |=> !clk_en_o); // R8
endmodule

// File: rtl/sdram_beat_gen.sv
module sdram_beat_gen
  import sdram_dq_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    clk_en_i,
  input  dq_cmd_e cmd_i,
  input  logic    burst_act_i,
  output logic    beat_rd_o,
  output logic    beat_wr_o
);
  dq_dir_e dir_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q <= DIR_NONE;
    end else if (clk_en_i) begin
      unique case (cmd_i)
        CMD_RD:   dir_q <= DIR_RD;
        CMD_WR:   dir_q <= DIR_WR;
        CMD_STOP: dir_q <= DIR_NONE;
        default:  dir_q <= dir_q;
      endcase
    end
  end

  // a command cycle is itself a beat; burst_act only extends an open burst
  always_comb begin
    beat_rd_o = 1'b0;
    beat_wr_o = 1'b0;
    if (clk_en_i) begin
      unique case (cmd_i)
        CMD_RD:  beat_rd_o = 1'b1;
        CMD_WR:  beat_wr_o = 1'b1;
        CMD_NOP: begin
          beat_rd_o = burst_act_i && (dir_q == DIR_RD);
          beat_wr_o = burst_act_i && (dir_q == DIR_WR);
        end
        default: ;
      endcase
    end
  end

  AST_STOP_ENDS_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_en_i && cmd_i == CMD_STOP) |=> (!beat_wr_o || cmd_i == CMD_WR)); // R7
endmodule

// File: rtl/sdram_rd_pipe.sv
module sdram_rd_pipe
  import sdram_dq_pkg::*;
#(
  parameter int unsigned LANES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clk_en_i,
  input  logic             cas_lat3_i,
  input  logic             beat_rd_i,
  input  logic             wr_busy_i,
  input  logic [LANES-1:0] dqm_i,
  output logic             rd_valid_o,
  output logic [LANES-1:0] rd_en_o
);
  logic [CL_MAX-1:0]                rd_sr;
  logic [DQM_LAT-1:0][LANES-1:0]    dqm_sr;
  logic                             tap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_sr  <= '0;
      dqm_sr <= '0;
    end else if (clk_en_i) begin
      rd_sr  <= {rd_sr[CL_MAX-2:0], beat_rd_i};
      dqm_sr <= {dqm_sr[DQM_LAT-2:0], dqm_i};
    end
  end

  assign tap        = cas_lat3_i ? rd_sr[CL_MAX-1] : rd_sr[CL_MAX-2];
  // capture once per beat; a write beat owns the bus
  assign rd_valid_o = tap && clk_en_i && !wr_busy_i;
  assign rd_en_o    = {LANES{rd_valid_o}} & ~dqm_sr[DQM_LAT-1];

  AST_PIPE_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clk_en_i |=> ($stable(rd_sr) && $stable(dqm_sr))); // R8
endmodule

// File: rtl/sdram_wr_mask.sv
module sdram_wr_mask #(
  parameter int unsigned LANES = 2
) (
  input  logic             beat_wr_i,
  input  logic [LANES-1:0] dqm_i,
  output logic [LANES-1:0] wr_strb_o,
  output logic             dq_oe_o
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign wr_strb_o[l] = beat_wr_i && !dqm_i[l];
  end

  assign dq_oe_o = beat_wr_i;
endmodule

// File: rtl/sdram_dq_path.sv
module sdram_dq_path
  import sdram_dq_pkg::*;
#(
  parameter int unsigned LANES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       cmd_i,
  input  logic             cas_lat3_i,
  input  logic [LANES-1:0] dqm_i,
  input  logic             burst_act_i,
  input  logic             cke_i,
  output logic             rd_valid_o,
  output logic [LANES-1:0] rd_en_o,
  output logic [LANES-1:0] wr_strb_o,
  output logic             dq_oe_o
);
  logic clk_en;
  logic beat_rd;
  logic beat_wr;

  sdram_cke_sync u_cke (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cke_i    (cke_i),
    .clk_en_o (clk_en)
  );

  sdram_beat_gen u_beat (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clk_en_i    (clk_en),
    .cmd_i       (dq_cmd_e'(cmd_i)),
    .burst_act_i (burst_act_i),
    .beat_rd_o   (beat_rd),
    .beat_wr_o   (beat_wr)
  );

  sdram_rd_pipe #(.LANES(LANES)) u_rd (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clk_en_i   (clk_en),
    .cas_lat3_i (cas_lat3_i),
    .beat_rd_i  (beat_rd),
    .wr_busy_i  (beat_wr),
    .dqm_i      (dqm_i),
    .rd_valid_o (rd_valid_o),
    .rd_en_o    (rd_en_o)
  );

  sdram_wr_mask #(.LANES(LANES)) u_wr (
    .beat_wr_i (beat_wr),
    .dqm_i     (dqm_i),
    .wr_strb_o (wr_strb_o),
    .dq_oe_o   (dq_oe_o)
  );

  AST_OE_RD_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(dq_oe_o && rd_valid_o)); // R9
  AST_STRB_NEEDS_OE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|wr_strb_o) |-> dq_oe_o); // R5
  AST_SUSPEND_NO_OE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(cke_i) |-> !dq_oe_o); // R8

  for (genvar l = 0; l < LANES; l++) begin : g_chk
    AST_WR_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      dqm_i[l] |-> !wr_strb_o[l]); // R5
    AST_RD_EN_IN_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rd_en_o[l] |-> rd_valid_o); // R4
  end
endmodule

// File: tb/sim_sdram_dq_path.sv
module sim_sdram_dq_path;
  localparam int unsigned LANES = 2;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic [1:0]       cmd_i = 2'b00;
  logic             cas_lat3_i = 1'b0;
  logic [LANES-1:0] dqm_i = '0;
  logic             burst_act_i = 1'b0;
  logic             cke_i = 1'b1;
  logic             rd_valid_o;
  logic [LANES-1:0] rd_en_o;
  logic [LANES-1:0] wr_strb_o;
  logic             dq_oe_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  sdram_dq_path #(.LANES(LANES)) u0 (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .cmd_i       (cmd_i),
    .cas_lat3_i  (cas_lat3_i),
    .dqm_i       (dqm_i),
    .burst_act_i (burst_act_i),
    .cke_i       (cke_i),
    .rd_valid_o  (rd_valid_o),
    .rd_en_o     (rd_en_o),
    .wr_strb_o   (wr_strb_o),
    .dq_oe_o     (dq_oe_o)
  );

  // {cl3, cmd, dqm, burst, cke, exp_valid, exp_en, exp_strb, exp_oe, req}
  localparam int unsigned NV = 21;
  localparam logic [16:0] VEC [NV] = '{
    {1'b0, 2'b01, 2'b00, 1'b1, 1'b1, 1'b0, 2'b00, 2'b00, 1'b0, 4'd2}, // R2 read cmd
    {1'b0, 2'b00, 2'b00, 1'b1, 1'b1, 1'b0, 2'b00, 2'b00, 1'b0, 4'd2}, // R2
    {1'b0, 2'b00, 2'b10, 1'b1, 1'b1, 1'b1, 2'b11, 2'b00, 1'b0, 4'd2}, // R2 first beat back
    {1'b0, 2'b00, 2'b00, 1'b1, 1'b1, 1'b1, 2'b11, 2'b00, 1'b0, 4'd2}, // R2
    {1'b0, 2'b00, 2'b00, 1'b0, 1'b1, 1'b1, 2'b01, 2'b00, 1'b0, 4'd4}, // R4 R6 upper masked
    {1'b0, 2'b00, 2'b00, 1'b0, 1'b1, 1'b1, 2'b11, 2'b00, 1'b0, 4'd4}, // R4
    {1'b0, 2'b00, 2'b00, 1'b0, 1'b1, 1'b0, 2'b00, 2'b00, 1'b0, 4'd2}, // R2 burst over
    {1'b0, 2'b10, 2'b01, 1'b1, 1'b1, 1'b0, 2'b00, 2'b10, 1'b1, 4'd6}, // R5 R6 lower masked
    {1'b0, 2'b00, 2'b00, 1'b1, 1'b1, 1'b0, 2'b00, 2'b11, 1'b1, 4'd5}, // R5
    {1'b0, 2'b11, 2'b00, 1'b1, 1'b1, 1'b0, 2'b00, 2'b00, 1'b0, 4'd7}, // R7 stop
    {1'b0, 2'b00, 2'b00, 1'b1, 1'b1, 1'b0, 2'b00, 2'b00, 1'b0, 4'd7}, // R7 burst ignored
    {1'b0, 2'b00, 2'b00, 1'b0, 1'b1, 1'b0, 2'b00, 2'b00, 1'b0, 4'd7}, // R7
    {1'b0, 2'b01, 2'b00, 1'b0, 1'b1, 1'b0, 2'b00, 2'b00, 1'b0, 4'd9}, // R9 single read
    {1'b0, 2'b00, 2'b00, 1'b0, 1'b1, 1'b0, 2'b00, 2'b00, 1'b0, 4'd9}, // R9
    {1'b0, 2'b10, 2'b00, 1'b0, 1'b1, 1'b0, 2'b00, 2'b11, 1'b1, 4'd9}, // R9 collision drops read
    {1'b0, 2'b00, 2'b00, 1'b0, 1'b1, 1'b0, 2'b00, 2'b00, 1'b0, 4'd9}, // R9
    {1'b1, 2'b01, 2'b00, 1'b0, 1'b1, 1'b0, 2'b00, 2'b00, 1'b0, 4'd3}, // R3 read at CL3
    {1'b1, 2'b00, 2'b01, 1'b0, 1'b1, 1'b0, 2'b00, 2'b00, 1'b0, 4'd3}, // R3
    {1'b1, 2'b00, 2'b00, 1'b0, 1'b1, 1'b0, 2'b00, 2'b00, 1'b0, 4'd3}, // R3 not yet at 2
    {1'b1, 2'b00, 2'b00, 1'b0, 1'b1, 1'b1, 2'b10, 2'b00, 1'b0, 4'd3}, // R3 R4 back at 3
    {1'b1, 2'b00, 2'b00, 1'b0, 1'b1, 1'b0, 2'b00, 2'b00, 1'b0, 4'd3}  // R3
  };

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic step(input logic cl3, input logic [1:0] cmd, input logic [1:0] dqm,
                      input logic ba, input logic cke, input logic ev, input logic [1:0] een,
                      input logic [1:0] estrb, input logic eoe, input string tag);
    @(negedge clk);
    cas_lat3_i  = cl3;
    cmd_i       = cmd;
    dqm_i       = dqm;
    burst_act_i = ba;
    cke_i       = cke;
    #4;
    chk(tag, "rd_valid", int'(rd_valid_o), int'(ev));
    chk(tag, "rd_en",    int'(rd_en_o),    int'(een));
    chk(tag, "wr_strb",  int'(wr_strb_o),  int'(estrb));
    chk(tag, "dq_oe",    int'(dq_oe_o),    int'(eoe));
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1: reset with a write command presented
    cmd_i = 2'b10;
    burst_act_i = 1'b1;
    #8;
    chk("R1", "dq_oe",    int'(dq_oe_o),    0);
    chk("R1", "wr_strb",  int'(wr_strb_o),  0);
    chk("R1", "rd_valid", int'(rd_valid_o), 0);
    @(negedge clk);
    cmd_i = 2'b00;
    burst_act_i = 1'b0;
    rst_ni = 1'b1;
    #4;
    chk("R1", "rd_en", int'(rd_en_o), 0);
    step(1'b0, 2'b00, 2'b00, 1'b0, 1'b1, 1'b0, 2'b00, 2'b00, 1'b0, "R1");
    step(1'b0, 2'b00, 2'b00, 1'b0, 1'b1, 1'b0, 2'b00, 2'b00, 1'b0, "R1");

    for (int i = 0; i < int'(NV); i++) begin
      step(VEC[i][16], VEC[i][15:14], VEC[i][13:12], VEC[i][11], VEC[i][10],
           VEC[i][9], VEC[i][8:7], VEC[i][6:5], VEC[i][4], $sformatf("R%0d", VEC[i][3:0]));
    end

    // R8: suspend mid read burst at CL2, write command while frozen is ignored
    step(1'b0, 2'b01, 2'b00, 1'b0, 1'b1, 1'b0, 2'b00, 2'b00, 1'b0, "R8");
    step(1'b0, 2'b00, 2'b00, 1'b1, 1'b0, 1'b0, 2'b00, 2'b00, 1'b0, "R8");
    step(1'b0, 2'b10, 2'b00, 1'b0, 1'b0, 1'b0, 2'b00, 2'b00, 1'b0, "R8");
    step(1'b0, 2'b00, 2'b00, 1'b0, 1'b1, 1'b0, 2'b00, 2'b00, 1'b0, "R8");
    step(1'b0, 2'b00, 2'b00, 1'b1, 1'b1, 1'b1, 2'b11, 2'b00, 1'b0, "R8");
    step(1'b0, 2'b00, 2'b00, 1'b0, 1'b1, 1'b1, 2'b11, 2'b00, 1'b0, "R8");
    step(1'b0, 2'b00, 2'b00, 1'b0, 1'b1, 1'b1, 2'b11, 2'b00, 1'b0, "R8");
    step(1'b0, 2'b00, 2'b00, 1'b0, 1'b1, 1'b0, 2'b00, 2'b00, 1'b0, "R8");

    // R5 R8: write beat blocked in a suspended cycle, resumes after
    step(1'b0, 2'b10, 2'b00, 1'b1, 1'b0, 1'b0, 2'b00, 2'b11, 1'b1, "R5");
    step(1'b0, 2'b00, 2'b00, 1'b1, 1'b1, 1'b0, 2'b00, 2'b00, 1'b0, "R8");
    step(1'b0, 2'b00, 2'b10, 1'b1, 1'b1, 1'b0, 2'b00, 2'b01, 1'b1, "R8");
    step(1'b0, 2'b11, 2'b00, 1'b0, 1'b1, 1'b0, 2'b00, 2'b00, 1'b0, "R7");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule